// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor bus read a serial flash as if it were plain memory. When the pins are not being driven by hand, a read request carrying a byte offset becomes a fast-read transaction on the single flash select line. The engine sends command byte 0x0B, then the three offset bytes, then one dummy byte. It then clocks in four data bytes and hands them back as one 32-bit word with a single-cycle valid pulse.

A manual mode input hands the pins back to three software-held values (select, clock, data out). The flash address is the byte offset of the access within the window. The serial clock runs at a quarter of the system clock in SPI mode 0. Only one request is in flight at a time, and a ready output shows when a new one can be taken.

Top module: `spi_xip_reader`

## Requirements
- R1: During and right after reset, spi_cs0_n is 1, spi_sclk is 0, rd_valid is 0 and rd_ready is 1 (with manual mode off).
- R2: An accepted request drives spi_cs0_n low while spi_sclk is still low. The first 8 bits on spi_mosi are 0x0B, most significant bit first.
- R3: The next 24 bits on spi_mosi are rd_addr, most significant bit first.
- R4: After the address comes one dummy byte (8 clocks), then 32 data clocks. spi_mosi is 0 throughout dummy and data.
- R5: rd_data holds the four received bytes, the first in bits 7:0 and the fourth in bits 31:24. Within each byte the first bit received is the most significant.
- R6: spi_sclk idles low and has a period of 4 system clocks. spi_mosi changes only while spi_sclk is low, and spi_miso is sampled while spi_sclk is high. Each transaction has exactly 72 rising edges.
- R7: rd_valid is a one-cycle pulse. It rises in the cycle spi_cs0_n returns high after the last data clock.
- R8: After a transaction, spi_cs0_n stays high for at least 2 cycles, and rd_ready returns 2 cycles after rd_valid. While a transaction is in flight, rd_ready is 0 and rd_req is ignored.
- R9: While gpio_mode is 1, the pins equal man_cs0_n, man_sclk and man_mosi, rd_ready is 0 and requests are ignored. Setting gpio_mode mid-transaction abandons it with no rd_valid. Clearing gpio_mode leaves the engine idle with the select line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_mode | input | 1 | 1 hands the pins to the manual values |
| man_cs0_n | input | 1 | Manual select level |
| man_sclk | input | 1 | Manual clock level |
| man_mosi | input | 1 | Manual data-out level |
| rd_req | input | 1 | Read request, taken when rd_ready is 1 |
| rd_addr | input | 24 | Byte offset within the flash window |
| rd_ready | output | 1 | Engine idle and able to accept a request |
| rd_valid | output | 1 | One-cycle pulse, rd_data is valid |
| rd_data | output | 32 | Assembled read word |
| spi_cs0_n | output | 1 | Flash select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench uses all-zero and all-one offsets, which show an address byte dropped or sent in the wrong order, and a flash model whose bytes differ per offset, which exposes byte lanes swapped or bits reversed within a byte. A request pulsed in mid-transfer checks that a design accepting it would corrupt the frame in flight or start a second one. An abort by manual mode checks that no stale valid pulse is produced and the select line does not stay low. Counting clock edges and the select-high gap catches a wrong dummy length or a missing recovery time.

// File: rtl/spi_xip_reader.sv
module spi_xip_reader #(
  parameter int ADDR_BYTES  = 3,
  parameter int DUMMY_BYTES = 1,
  parameter int GAP_CYC     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gpio_mode,
  input  logic                    man_cs0_n,
  input  logic                    man_sclk,
  input  logic                    man_mosi,
  input  logic                    rd_req,
  input  logic [8*ADDR_BYTES-1:0] rd_addr,
  output logic                    rd_ready,
  output logic                    rd_valid,
  output logic [31:0]             rd_data,
  output logic                    spi_cs0_n,
  output logic                    spi_sclk,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);
  localparam logic [7:0] CMD = 8'h0B;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int HDR_W      = 8 + ADDR_W;
  localparam int TOTAL      = HDR_W + 8 * DUMMY_BYTES + 32;
  localparam int DATA_START = TOTAL - 32;
  localparam int CW         = $clog2(TOTAL);
  localparam int GW         = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  st_t              st;
  logic [1:0]       ph;
  logic [CW-1:0]    bitcnt;
  logic [GW-1:0]    gap;
  logic [HDR_W-1:0] sh;
  logic [4:0]       didx;

  assign didx = 5'(bitcnt - CW'(DATA_START));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= '0;
      bitcnt   <= '0;
      gap      <= '0;
      sh       <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (gpio_mode) begin
        st <= S_IDLE;
        ph <= '0;
      end else begin
        case (st)
          S_IDLE: if (rd_req) begin
            sh     <= {CMD, rd_addr};
            bitcnt <= '0;
            ph     <= '0;
            st     <= S_SHIFT;
          end
          S_SHIFT: begin
            ph <= ph + 2'd1;
            if (ph == 2'd2 && bitcnt >= CW'(DATA_START))
              rd_data[{didx[4:3], ~didx[2:0]}] <= spi_miso;
            if (ph == 2'd3) begin
              sh <= {sh[HDR_W-2:0], 1'b0};
              if (bitcnt == CW'(TOTAL - 1)) begin
                st       <= S_GAP;
                gap      <= '0;
                rd_valid <= 1'b1;
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          S_GAP: begin
            if (gap == GW'(GAP_CYC - 1)) st <= S_IDLE;
            else gap <= gap + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  wire busy = (st == S_SHIFT);

  assign rd_ready  = !gpio_mode && (st == S_IDLE);
  assign spi_cs0_n = gpio_mode ? man_cs0_n : !busy;
  assign spi_sclk  = gpio_mode ? man_sclk  : (busy && ph[1]);
  assign spi_mosi  = gpio_mode ? man_mosi  : (busy && sh[HDR_W-1]);
endmodule

module spi_xip_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic gpio_mode,
  input logic rd_ready,
  input logic rd_valid,
  input logic spi_cs0_n,
  input logic spi_sclk,
  input logic spi_mosi
);
  a_r6_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!gpio_mode && spi_cs0_n) |-> !spi_sclk);

  a_r6_mosi_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!gpio_mode && !spi_cs0_n && spi_sclk) |=> (gpio_mode || !spi_sclk || $stable(spi_mosi)));

  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r7_valid_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (spi_cs0_n && $past(!spi_cs0_n)));

  a_r8_cs_min_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!gpio_mode && $rose(spi_cs0_n)) |=> (gpio_mode || spi_cs0_n));

  a_r8_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!gpio_mode && !spi_cs0_n) |-> !rd_ready);

  a_r9_no_ready_manual: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_mode |-> !rd_ready);
endmodule

bind spi_xip_reader spi_xip_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gpio_mode(gpio_mode), .rd_ready(rd_ready),
  .rd_valid(rd_valid), .spi_cs0_n(spi_cs0_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/spi_xip_reader_bench.sv
module spi_xip_reader_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, gpio_mode = 1'b0;
  logic man_cs0_n = 1'b1, man_sclk = 1'b0, man_mosi = 1'b0;
  logic rd_req = 1'b0;
  logic [23:0] rd_addr = '0;
  logic rd_ready, rd_valid, spi_cs0_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;
  logic [31:0] rd_data;

  spi_xip_reader u_spi_xip_reader (
    .clk(clk), .rst_n(rst_n), .gpio_mode(gpio_mode), .man_cs0_n(man_cs0_n),
    .man_sclk(man_sclk), .man_mosi(man_mosi), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .spi_cs0_n(spi_cs0_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [23:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd7;
    return m ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] exp_word(input logic [23:0] a);
    return {byte_at(a + 24'd3), byte_at(a + 24'd2), byte_at(a + 24'd1), byte_at(a)};
  endfunction

  // flash model
  int bcnt = 0, last_bits = 0, per_bad = 0;
  time last_rise = 0;
  logic [31:0] hdr = '0;
  bit mosi_hi_seen = 0;

  always @(posedge spi_sclk or posedge spi_cs0_n) begin
    if (spi_cs0_n) begin
      last_bits = bcnt;
      bcnt = 0;
      last_rise = 0;
    end else begin
      if (last_rise != 0 && ($time - last_rise) != 4 * CLK_P) per_bad++;
      last_rise = $time;
      if (bcnt < 32) hdr = {hdr[30:0], spi_mosi};
      else if (spi_mosi) mosi_hi_seen = 1;
      bcnt++;
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs0_n && bcnt >= 40 && bcnt < 72) begin
      logic [7:0] bv;
      int k, b;
      k = (bcnt - 40) / 8;
      b = 7 - ((bcnt - 40) % 8);
      bv = byte_at(hdr[23:0] + 24'(k));
      spi_miso = bv[b];
    end else begin
      spi_miso = 1'b0;
    end
  end

  task automatic wait_ready();
    for (int w = 0; w < 1000 && !rd_ready; w++) @(negedge clk);
  endtask

  task automatic wait_valid();
    for (int w = 0; w < 2000 && !rd_valid; w++) @(negedge clk);
  endtask

  task automatic do_read(input logic [23:0] a);
    int g;
    wait_ready();
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    chk(spi_cs0_n == 1'b0 && spi_sclk == 1'b0, "R2 select before clock", {spi_cs0_n, spi_sclk}, 2'b00);
    wait_valid();
    chk(rd_valid == 1'b1, "R7 valid seen", rd_valid, 1);
    chk(spi_cs0_n == 1'b1, "R7 select high at valid", spi_cs0_n, 1);
    chk(rd_data == exp_word(a), "R5 data assembly", rd_data, exp_word(a));
    chk(hdr[31:24] == 8'h0B, "R2 opcode", hdr[31:24], 8'h0B);
    chk(hdr[23:0] == a, "R3 address", hdr[23:0], a);
    chk(last_bits == 72, "R4 R6 clock count", last_bits, 72);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R7 single pulse", rd_valid, 0);
    g = 0;
    for (int w = 0; w < 20 && !rd_ready; w++) begin @(negedge clk); g++; end
    chk(g == 1, "R8 ready returns two cycles after valid", g, 1);
  endtask

  localparam logic [23:0] ADDRS [6] = '{24'h000000, 24'hFFFFFF, 24'h123456,
                                        24'hA5A5A5, 24'h00FF00, 24'h800001};

  initial begin
    // R1 reset
    @(negedge clk);
    chk(spi_cs0_n == 1 && spi_sclk == 0 && rd_valid == 0, "R1 pins in reset",
        {spi_cs0_n, spi_sclk, rd_valid}, 3'b100);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rd_ready == 1 && spi_cs0_n == 1 && spi_sclk == 0, "R1 after reset",
        {rd_ready, spi_cs0_n, spi_sclk}, 3'b110);

    foreach (ADDRS[i]) do_read(ADDRS[i]);

    // R8 request while busy ignored
    wait_ready();
    rd_req = 1'b1; rd_addr = 24'h0ABCDE;
    @(negedge clk); rd_req = 1'b0;
    repeat (30) @(negedge clk);
    chk(rd_ready == 0, "R8 not ready while busy", rd_ready, 0);
    rd_req = 1'b1; rd_addr = 24'h654321;
    @(negedge clk); rd_req = 1'b0;
    wait_valid();
    chk(rd_data == exp_word(24'h0ABCDE), "R8 busy request ignored data", rd_data, exp_word(24'h0ABCDE));
    chk(hdr[23:0] == 24'h0ABCDE, "R8 busy request ignored address", hdr[23:0], 24'h0ABCDE);
    begin
      bit low_seen = 0;
      repeat (20) begin @(negedge clk); if (!spi_cs0_n) low_seen = 1; end
      chk(!low_seen, "R8 no second frame", low_seen, 0);
    end

    // R9 manual pass-through
    gpio_mode = 1'b1;
    for (int p = 0; p < 8; p++) begin
      {man_cs0_n, man_sclk, man_mosi} = 3'(p);
      rd_req = 1'b1; rd_addr = 24'h111111;
      @(negedge clk);
      chk({spi_cs0_n, spi_sclk, spi_mosi} == 3'(p) && !rd_ready, "R9 manual pins",
          {rd_ready, spi_cs0_n, spi_sclk, spi_mosi}, 3'(p));
    end
    rd_req = 1'b0;
    {man_cs0_n, man_sclk, man_mosi} = 3'b100;
    @(negedge clk);
    gpio_mode = 1'b0;
    @(negedge clk);
    chk(spi_cs0_n == 1 && rd_ready == 1, "R9 request in manual mode ignored",
        {spi_cs0_n, rd_ready}, 2'b11);

    // R9 abort mid-transaction
    rd_req = 1'b1; rd_addr = 24'h777777;
    @(negedge clk); rd_req = 1'b0;
    repeat (100) @(negedge clk);
    gpio_mode = 1'b1; man_mosi = 1'b0;
    begin
      bit v_seen = 0;
      repeat (400) begin @(negedge clk); if (rd_valid) v_seen = 1; end
      chk(!v_seen, "R9 abort gives no valid", v_seen, 0);
    end
    gpio_mode = 1'b0;
    @(negedge clk);
    chk(spi_cs0_n == 1 && spi_sclk == 0 && rd_ready == 1, "R9 idle after abort",
        {spi_cs0_n, spi_sclk, rd_ready}, 3'b101);
    do_read(24'h3C3C3C);

    chk(per_bad == 0, "R6 clock period", per_bad, 0);
    chk(mosi_hi_seen == 0, "R4 mosi low in dummy and data", mosi_hi_seen, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule